// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the software-visible configuration of a two-chip-select SDRAM controller. A host reaches it over a simple 32-bit register bus with a select, a write enable, an access-size code, a 12-bit byte address and write data. Every access completes in one cycle. Read data and an error pulse come back on the following clock edge.

Some registers are global: system configuration, chip-select configuration, sharing, delay-line control and power. Each chip select also has its own set: memory configuration, mode, extended mode, two timing words, refresh and manual command. The two chip-select windows share one local layout. The exception is the timing words, which sit at different local offsets in each window.

Every stored register applies its own write mask. The sharing register and each memory-configuration register freeze once their lock bit is stored. The memory-configuration mask depends on bit 19 of the value being written. A write to the system configuration register with bit 1 set returns the whole file to its reset values. Unmapped, read-only and narrow accesses raise the error output. The command sequencing, the refresh engine and the delay-line hardware are not part of this block.

Top module: `sdrc_cfg_regs`

## Requirements
- R1: Reads of 0x00 return 0x20, of 0x14 return 1, of 0x48 return 0 and of 0x4C return 0x8.
- R2: After reset, 0x10 reads 0x10, 0x40 reads 0x4, 0x70 reads 0x85, each mode register (0x84, 0xB4) reads 0x024, and every other stored register reads 0.
- R3: A write to 0x10 with bit 1 set first restores every register to its R2 value. In every case 0x10 then holds only bits 4:3 of the written word.
- R4: A write to 0x44 stores value & 0x40007F00 only while the stored bit 30 is 0. Once bit 30 is stored, writes have no effect until a reset.
- R5: A write to a memory-configuration register (0x80, 0xB0) has no effect while its stored bit 30 is 1. Otherwise it stores value & 0x477BFFDF when bit 19 of the value is 1, and value & 0x41FBFFDF when bit 19 is 0.
- R6: The stored masks are as follows: 0x40 0x30F, 0x60 0xFFFF00FE, 0x70 0x04FFFFFD, mode and extended-mode-2 0xFFF, timing A 0xFFFFFFDF, timing B 0x000377FF, refresh 0x00FFFF03, manual 0xFFFF000F.
- R7: Chip select 0 uses base 0x80 and chip select 1 uses base 0xB0. The local offsets are: memory config 0x00, mode 0x04, extended mode 1 0x08, extended mode 2 0x0C, extended mode 3 0x10, refresh 0x24, manual 0x28. Each chip select keeps its own copy.
- R8: The timing A/B words sit at 0x9C/0xA0 for chip select 0 and at 0xC4/0xC8 for chip select 1. Addresses 0x94/0x98 read 0 and ignore writes without error. Addresses 0xCC/0xD0 are unmapped.
- R9: 0x64 reads the bitwise inverse of (value at 0x60 & 0x4). 0x68 and 0x6C read 0. Writes to 0x68 and to extended modes 1 and 3 (0x88, 0x90, 0xB8, 0xC0) are dropped without error, and those extended modes read 0.
- R10: A write to 0x00, 0x14, 0x48, 0x4C, 0x64 or 0x6C raises the error and changes no register.
- R11: Any access with bus_size other than 2'b10 (32-bit), and any read or write of an unmapped or misaligned address, raises the error and has no effect.
- R12: bus_rdata and bus_err are registered and reflect the access of the previous cycle. bus_rdata is 0 after any cycle that was not an error-free read, and both outputs are 0 out of reset.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code; 2'b10 = 32-bit, all other codes are errors |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error pulse, one cycle after the access |

## Verification
Several write patterns are used. All-ones words show every mask bit and set the locks. Words with bit 19 set and then clear separate the two memory-configuration masks. Mixed-pattern writes to chip select 1 followed by reads of chip select 0 show that the windows are independent and that the timing words sit at the right offsets. A pseudo-random sweep over every writable address, with a software reset in the middle, checks that locks, masks and the reset path interact correctly. A behavioural model kept in the bench predicts read data and error for each access.

// File: rtl/sdrc_cfg_pkg.sv
`timescale 1ns/1ps
package sdrc_cfg_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int NUM_CS  = 2;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  localparam logic [ADDR_W-1:0] CS0_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] CS0_LAST = 12'h0A8;
  localparam logic [ADDR_W-1:0] CS1_BASE = 12'h0B0;
  localparam logic [ADDR_W-1:0] CS1_LAST = 12'h0D8;

  localparam logic [DATA_W-1:0] RST_SYSCFG = 32'h10;
  localparam logic [DATA_W-1:0] RST_CSCFG  = 32'h4;
  localparam logic [DATA_W-1:0] RST_POWER  = 32'h85;
  localparam logic [DATA_W-1:0] RST_MODE   = 32'h24;

  localparam logic [DATA_W-1:0] MSK_SYSCFG = 32'h0000_0018;
  localparam logic [DATA_W-1:0] MSK_CSCFG  = 32'h0000_030F;
  localparam logic [DATA_W-1:0] MSK_SHARE  = 32'h4000_7F00;
  localparam logic [DATA_W-1:0] MSK_DLL    = 32'hFFFF_00FE;
  localparam logic [DATA_W-1:0] MSK_POWER  = 32'h04FF_FFFD;
  localparam logic [DATA_W-1:0] MSK_MODE   = 32'h0000_0FFF;
  localparam logic [DATA_W-1:0] MSK_TIMA   = 32'hFFFF_FFDF;
  localparam logic [DATA_W-1:0] MSK_TIMB   = 32'h0003_77FF;
  localparam logic [DATA_W-1:0] MSK_RFR    = 32'h00FF_FF03;
  localparam logic [DATA_W-1:0] MSK_MAN    = 32'hFFFF_000F;
  localparam logic [DATA_W-1:0] MSK_MCFG_W = 32'h477B_FFDF;
  localparam logic [DATA_W-1:0] MSK_MCFG_N = 32'h41FB_FFDF;

  localparam int LOCK_BIT  = 30;
  localparam int WIDEN_BIT = 19;
  localparam int SRST_BIT  = 1;

  typedef enum logic [4:0] {
    K_NONE, K_REV, K_SYSCFG, K_SYSSTAT, K_CSCFG, K_SHARE, K_ERRADDR,
    K_ERRTYPE, K_DLLA, K_DLLA_ST, K_DLLB, K_DLLB_ST, K_POWER,
    K_MCFG, K_MODE, K_EMODE1, K_EMODE2, K_EMODE3, K_TIMA, K_TIMB,
    K_DELAY, K_RFR, K_MAN
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    logic      cs;
    reg_kind_e kind;
  } dec_t;

  function automatic logic kind_is_ro(input reg_kind_e k);
    return (k inside {K_REV, K_SYSSTAT, K_ERRADDR, K_ERRTYPE, K_DLLA_ST, K_DLLB_ST});
  endfunction

  function automatic logic [DATA_W-1:0] mcfg_mask(input logic [DATA_W-1:0] v);
    return v[WIDEN_BIT] ? MSK_MCFG_W : MSK_MCFG_N;
  endfunction

  function automatic logic [DATA_W-1:0] dll_status(input logic [DATA_W-1:0] ctrl);
    return ~(ctrl & 32'h4);
  endfunction
endpackage

// File: rtl/sdrc_addr_decode.sv
`timescale 1ns/1ps
module sdrc_addr_decode
  import sdrc_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic              win0, win1, aligned;
  logic [ADDR_W-1:0] off;
  reg_kind_e         kind_glb, kind_win;

  assign aligned = (addr[1:0] == 2'b00);
  assign win0    = (addr >= CS0_BASE) && (addr <= CS0_LAST);
  assign win1    = (addr >= CS1_BASE) && (addr <= CS1_LAST);
  assign off     = win1 ? (addr - CS1_BASE) : (addr - CS0_BASE);

  always_comb begin
    case (addr)
      12'h000: kind_glb = K_REV;
      12'h010: kind_glb = K_SYSCFG;
      12'h014: kind_glb = K_SYSSTAT;
      12'h040: kind_glb = K_CSCFG;
      12'h044: kind_glb = K_SHARE;
      12'h048: kind_glb = K_ERRADDR;
      12'h04C: kind_glb = K_ERRTYPE;
      12'h060: kind_glb = K_DLLA;
      12'h064: kind_glb = K_DLLA_ST;
      12'h068: kind_glb = K_DLLB;
      12'h06C: kind_glb = K_DLLB_ST;
      12'h070: kind_glb = K_POWER;
      default: kind_glb = K_NONE;
    endcase
  end

  // timing words move between windows; the free slots differ per window
  always_comb begin
    case (off)
      12'h000: kind_win = K_MCFG;
      12'h004: kind_win = K_MODE;
      12'h008: kind_win = K_EMODE1;
      12'h00C: kind_win = K_EMODE2;
      12'h010: kind_win = K_EMODE3;
      12'h014: kind_win = win1 ? K_TIMA : K_DELAY;
      12'h018: kind_win = win1 ? K_TIMB : K_DELAY;
      12'h01C: kind_win = win1 ? K_NONE : K_TIMA;
      12'h020: kind_win = win1 ? K_NONE : K_TIMB;
      12'h024: kind_win = K_RFR;
      12'h028: kind_win = K_MAN;
      default: kind_win = K_NONE;
    endcase
  end

  always_comb begin
    dec.cs   = win1;
    dec.kind = (win0 || win1) ? kind_win : kind_glb;
    dec.hit  = aligned && (dec.kind != K_NONE);
  end
endmodule

// File: rtl/sdrc_cs_bank.sv
`timescale 1ns/1ps
module sdrc_cs_bank
  import sdrc_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mcfg_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] emode2_q,
  output logic [DATA_W-1:0] tima_q,
  output logic [DATA_W-1:0] timb_q,
  output logic [DATA_W-1:0] rfr_q,
  output logic [DATA_W-1:0] man_q
);
  logic mcfg_locked;
  assign mcfg_locked = mcfg_q[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcfg_q <= '0; mode_q <= RST_MODE; emode2_q <= '0;
      tima_q <= '0; timb_q <= '0; rfr_q <= '0; man_q <= '0;
    end else if (soft_rst) begin
      mcfg_q <= '0; mode_q <= RST_MODE; emode2_q <= '0;
      tima_q <= '0; timb_q <= '0; rfr_q <= '0; man_q <= '0;
    end else if (wr_en) begin
      case (kind)
        K_MCFG:   if (!mcfg_locked) mcfg_q <= wdata & mcfg_mask(wdata);
        K_MODE:   mode_q   <= wdata & MSK_MODE;
        K_EMODE2: emode2_q <= wdata & MSK_MODE;
        K_TIMA:   tima_q   <= wdata & MSK_TIMA;
        K_TIMB:   timb_q   <= wdata & MSK_TIMB;
        K_RFR:    rfr_q    <= wdata & MSK_RFR;
        K_MAN:    man_q    <= wdata & MSK_MAN;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sdrc_cfg_regs.sv
`timescale 1ns/1ps
module sdrc_cfg_regs
  import sdrc_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);
  dec_t dec;
  sdrc_addr_decode u_dec (.addr(bus_addr), .dec(dec));

  // named events for the checker
  logic acc_ok, size_bad, wr_fire, rd_fire, soft_rst, acc_err, share_locked;
  assign acc_ok   = bus_sel && (bus_size == SIZE_WORD);
  assign size_bad = bus_sel && (bus_size != SIZE_WORD);
  assign wr_fire  = acc_ok && bus_we && dec.hit && !kind_is_ro(dec.kind);
  assign rd_fire  = acc_ok && !bus_we && dec.hit;
  assign soft_rst = wr_fire && (dec.kind == K_SYSCFG) && bus_wdata[SRST_BIT];
  assign acc_err  = size_bad || (acc_ok && !dec.hit) ||
                    (acc_ok && bus_we && dec.hit && kind_is_ro(dec.kind));

  logic [DATA_W-1:0] cfg_q, cscfg_q, share_q, dll_q, power_q;
  assign share_locked = share_q[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_SYSCFG; cscfg_q <= RST_CSCFG; share_q <= '0;
      dll_q <= '0; power_q <= RST_POWER;
    end else if (soft_rst) begin
      cfg_q <= bus_wdata & MSK_SYSCFG; cscfg_q <= RST_CSCFG; share_q <= '0;
      dll_q <= '0; power_q <= RST_POWER;
    end else if (wr_fire) begin
      case (dec.kind)
        K_SYSCFG: cfg_q   <= bus_wdata & MSK_SYSCFG;
        K_CSCFG:  cscfg_q <= bus_wdata & MSK_CSCFG;
        K_SHARE:  if (!share_locked) share_q <= bus_wdata & MSK_SHARE;
        K_DLLA:   dll_q   <= bus_wdata & MSK_DLL;
        K_POWER:  power_q <= bus_wdata & MSK_POWER;
        default:  ;
      endcase
    end
  end

  logic [DATA_W-1:0] cs_mcfg [NUM_CS];
  logic [DATA_W-1:0] cs_mode [NUM_CS];
  logic [DATA_W-1:0] cs_em2  [NUM_CS];
  logic [DATA_W-1:0] cs_tima [NUM_CS];
  logic [DATA_W-1:0] cs_timb [NUM_CS];
  logic [DATA_W-1:0] cs_rfr  [NUM_CS];
  logic [DATA_W-1:0] cs_man  [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic bank_wr;
    assign bank_wr = wr_fire && (int'(dec.cs) == g);
    sdrc_cs_bank u_bank (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(bank_wr),
      .kind(dec.kind), .wdata(bus_wdata),
      .mcfg_q(cs_mcfg[g]), .mode_q(cs_mode[g]), .emode2_q(cs_em2[g]),
      .tima_q(cs_tima[g]), .timb_q(cs_timb[g]), .rfr_q(cs_rfr[g]),
      .man_q(cs_man[g])
    );
  end

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    case (dec.kind)
      K_REV:     rd_val = 32'h20;
      K_SYSCFG:  rd_val = cfg_q;
      K_SYSSTAT: rd_val = 32'h1;
      K_CSCFG:   rd_val = cscfg_q;
      K_SHARE:   rd_val = share_q;
      K_ERRTYPE: rd_val = 32'h8;
      K_DLLA:    rd_val = dll_q;
      K_DLLA_ST: rd_val = dll_status(dll_q);
      K_POWER:   rd_val = power_q;
      K_MCFG:    rd_val = cs_mcfg[dec.cs];
      K_MODE:    rd_val = cs_mode[dec.cs];
      K_EMODE2:  rd_val = cs_em2[dec.cs];
      K_TIMA:    rd_val = cs_tima[dec.cs];
      K_TIMB:    rd_val = cs_timb[dec.cs];
      K_RFR:     rd_val = cs_rfr[dec.cs];
      K_MAN:     rd_val = cs_man[dec.cs];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_fire ? rd_val : '0;
      bus_err   <= acc_err;
    end
  end
endmodule

// File: rtl/sdrc_cfg_checker.sv
`timescale 1ns/1ps
module sdrc_cfg_checker
  import sdrc_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              soft_rst,
  input logic [DATA_W-1:0] share_q,
  input logic [DATA_W-1:0] mcfg0,
  input logic [DATA_W-1:0] mcfg1,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] cscfg_q,
  input logic [DATA_W-1:0] power_q
);
  assert_rev_const_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_size == SIZE_WORD && bus_addr == 12'h000)
    |=> (bus_rdata == 32'h20 && !bus_err));

  assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cscfg_q == RST_CSCFG && power_q == RST_POWER && share_q == '0
                  && mcfg0 == '0 && mcfg1 == '0
                  && cfg_q == ($past(bus_wdata) & MSK_SYSCFG)));

  assert_share_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (share_q[LOCK_BIT] && !soft_rst) |=> (share_q == $past(share_q)));

  assert_mcfg0_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcfg0[LOCK_BIT] && !soft_rst) |=> (mcfg0 == $past(mcfg0)));

  assert_mcfg1_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcfg1[LOCK_BIT] && !soft_rst) |=> (mcfg1 == $past(mcfg1)));

  assert_narrow_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SIZE_WORD) |=> (bus_err && bus_rdata == '0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (!bus_err && bus_rdata == '0));
endmodule

bind sdrc_cfg_regs sdrc_cfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .soft_rst(soft_rst),
  .share_q(share_q), .mcfg0(cs_mcfg[0]), .mcfg1(cs_mcfg[1]),
  .cfg_q(cfg_q), .cscfg_q(cscfg_q), .power_q(power_q)
);

// File: tb/test_sdrc_cfg_regs.sv
`timescale 1ns/1ps
module test_sdrc_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdrc_cfg_regs i_sdrc_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] st  [int];   // stored registers by address
  logic [31:0] rv  [int];   // their reset values
  logic [31:0] mk  [int];   // their write masks
  logic [31:0] cst [int];   // constant-read addresses
  int quiet [$];            // writes dropped without error
  int wlist [$];            // every address that stores state

  function automatic void add_reg(int a, logic [31:0] r, logic [31:0] m);
    rv[a] = r; mk[a] = m; wlist.push_back(a);
  endfunction

  function automatic void mdl_reset();
    foreach (rv[a]) st[a] = rv[a];
  endfunction

  function automatic void mdl_build();
    int bases [2] = '{32'h80, 32'hB0};
    add_reg(32'h10, 32'h10, 32'h18);
    add_reg(32'h40, 32'h4, 32'h30F);
    add_reg(32'h44, 32'h0, 32'h40007F00);
    add_reg(32'h60, 32'h0, 32'hFFFF00FE);
    add_reg(32'h70, 32'h85, 32'h04FFFFFD);
    foreach (bases[i]) begin
      add_reg(bases[i] + 32'h00, 32'h0, 32'h0);
      add_reg(bases[i] + 32'h04, 32'h24, 32'hFFF);
      add_reg(bases[i] + 32'h0C, 32'h0, 32'hFFF);
      add_reg(bases[i] + 32'h24, 32'h0, 32'h00FFFF03);
      add_reg(bases[i] + 32'h28, 32'h0, 32'hFFFF000F);
      cst[bases[i] + 32'h08] = 32'h0;
      cst[bases[i] + 32'h10] = 32'h0;
      quiet.push_back(bases[i] + 32'h08);
      quiet.push_back(bases[i] + 32'h10);
    end
    add_reg(32'h9C, 32'h0, 32'hFFFFFFDF);
    add_reg(32'hA0, 32'h0, 32'h000377FF);
    add_reg(32'hC4, 32'h0, 32'hFFFFFFDF);
    add_reg(32'hC8, 32'h0, 32'h000377FF);
    cst[32'h00] = 32'h20; cst[32'h14] = 32'h1; cst[32'h48] = 32'h0;
    cst[32'h4C] = 32'h8;  cst[32'h68] = 32'h0; cst[32'h6C] = 32'h0;
    cst[32'h94] = 32'h0;  cst[32'h98] = 32'h0;
    quiet.push_back(32'h68); quiet.push_back(32'h94); quiet.push_back(32'h98);
    mdl_reset();
  endfunction

  function automatic void mdl_access(input bit we, input int a, input logic [31:0] d,
                                     input logic [1:0] sz,
                                     output logic [31:0] er, output bit ee);
    bit is_quiet;
    er = 32'h0; ee = 0;
    is_quiet = 0;
    foreach (quiet[i]) if (quiet[i] == a) is_quiet = 1;
    if (sz != 2'b10) begin ee = 1; return; end
    if (we) begin
      if (st.exists(a)) begin
        if (a == 32'h10) begin
          if (d[1]) mdl_reset();
          st[a] = d & 32'h18;
        end else if ((a == 32'h44 || a == 32'h80 || a == 32'hB0) && st[a][30]) begin
          // frozen by its lock bit
        end else if (a == 32'h80 || a == 32'hB0) begin
          st[a] = d & (d[19] ? 32'h477BFFDF : 32'h41FBFFDF);
        end else begin
          st[a] = d & mk[a];
        end
      end else if (!is_quiet) ee = 1;
    end else begin
      if (st.exists(a)) er = st[a];
      else if (a == 32'h64) er = ~(st[32'h60] & 32'h4);
      else if (cst.exists(a)) er = cst[a];
      else ee = 1;
    end
  endfunction

  // ---------------- access and compare ----------------
  task automatic acc(input bit we, input int a, input logic [31:0] d,
                     input logic [1:0] sz, input string tag);
    logic [31:0] er;
    bit ee;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a[11:0]; bus_wdata = d; bus_size = sz;
    mdl_access(we, a, d, sz, er, ee);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'b10;
    total++;
    if (bus_rdata !== er) begin
      bad++;
      $display("FAIL %s rdata addr=%h we=%0d: actual=%h expected=%h", tag, a, we, bus_rdata, er);
    end
    total++;
    if (bus_err !== ee) begin
      bad++;
      $display("FAIL %s err addr=%h we=%0d: actual=%0d expected=%0d", tag, a, we, bus_err, ee);
    end
  endtask

  task automatic rd(input int a, input string tag);
    acc(1'b0, a, 32'h0, 2'b10, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    acc(1'b1, a, d, 2'b10, tag);
  endtask

  task automatic read_all(input string tag);
    foreach (wlist[i]) rd(wlist[i], tag);
    foreach (cst[a]) rd(a, tag);
    rd(32'h64, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    mdl_build();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (bus_rdata !== 32'h0 || bus_err !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset outputs: actual=%h/%0d expected=0/0", bus_rdata, bus_err);
    end

    read_all("R2");
    rd(32'h00, "R1"); rd(32'h14, "R1"); rd(32'h48, "R1"); rd(32'h4C, "R1");

    // mask and window independence: chip select 1 first, then chip select 0
    foreach (wlist[i]) if (wlist[i] >= 32'hB0 && wlist[i] != 32'hB0) wr(wlist[i], 32'hA5C3_5A3C, "R7");
    foreach (wlist[i]) if (wlist[i] >= 32'h80 && wlist[i] < 32'hB0 && wlist[i] != 32'h80) rd(wlist[i], "R7");
    foreach (wlist[i]) if (wlist[i] >= 32'h80 && wlist[i] < 32'hB0 && wlist[i] != 32'h80) wr(wlist[i], 32'hFFFF_FFFF, "R6");
    read_all("R6");
    wr(32'h40, 32'hFFFF_FFFF, "R6"); wr(32'h70, 32'hFFFF_FFFF, "R6"); wr(32'h60, 32'hFFFF_FFFF, "R6");
    rd(32'h40, "R6"); rd(32'h70, "R6"); rd(32'h60, "R6"); rd(32'h64, "R9");
    wr(32'h60, 32'h0000_0000, "R9"); rd(32'h64, "R9");

    // timing word placement per window
    wr(32'h9C, 32'h1111_1111, "R8"); wr(32'hC4, 32'h2222_2222, "R8");
    wr(32'hA0, 32'h3333_3333, "R8"); wr(32'hC8, 32'h0004_4444, "R8");
    wr(32'h94, 32'hFFFF_FFFF, "R8"); wr(32'h98, 32'hFFFF_FFFF, "R8");
    rd(32'h94, "R8"); rd(32'h98, "R8"); rd(32'h9C, "R8"); rd(32'hC4, "R8");
    rd(32'hA0, "R8"); rd(32'hC8, "R8");
    rd(32'hCC, "R8"); rd(32'hD0, "R8"); wr(32'hCC, 32'h1, "R8"); wr(32'hD0, 32'h1, "R8");

    // quiet writes
    wr(32'h68, 32'hFFFF_FFFF, "R9"); rd(32'h68, "R9"); rd(32'h6C, "R9");
    wr(32'h88, 32'hFFFF_FFFF, "R9"); wr(32'hB8, 32'hFFFF_FFFF, "R9");
    wr(32'h90, 32'hFFFF_FFFF, "R9"); wr(32'hC0, 32'hFFFF_FFFF, "R9");
    rd(32'h88, "R9"); rd(32'hC0, "R9");

    // memory config: narrow mask, wide mask, then lock
    wr(32'h80, 32'h1234_5678, "R5"); rd(32'h80, "R5");
    wr(32'h80, 32'h0F0F_FFFF, "R5"); rd(32'h80, "R5");
    wr(32'hB0, 32'hBFF7_FFFF, "R5"); rd(32'hB0, "R5");
    wr(32'h80, 32'hFFFF_FFFF, "R5"); rd(32'h80, "R5");
    wr(32'h80, 32'h0000_0000, "R5"); rd(32'h80, "R5"); rd(32'hB0, "R5");

    // sharing lock
    wr(32'h44, 32'h0000_FFFF, "R4"); rd(32'h44, "R4");
    wr(32'h44, 32'h4000_0100, "R4"); rd(32'h44, "R4");
    wr(32'h44, 32'h0000_0000, "R4"); rd(32'h44, "R4");

    // read-only and error accesses
    wr(32'h00, 32'hFFFF_FFFF, "R10"); wr(32'h14, 32'hFFFF_FFFF, "R10");
    wr(32'h48, 32'hFFFF_FFFF, "R10"); wr(32'h4C, 32'hFFFF_FFFF, "R10");
    wr(32'h64, 32'hFFFF_FFFF, "R10"); wr(32'h6C, 32'hFFFF_FFFF, "R10");
    rd(32'h00, "R10"); rd(32'h14, "R10"); rd(32'h4C, "R10");
    rd(32'h04, "R11"); rd(32'h50, "R11"); rd(32'hAC, "R11"); rd(32'hDC, "R11");
    rd(32'h82, "R11"); wr(32'h84, 32'h0, 32'h0 == 0 ? "R11" : "R11");
    acc(1'b1, 32'h40, 32'h0, 2'b00, "R11"); acc(1'b1, 32'h40, 32'h0, 2'b01, "R11");
    acc(1'b0, 32'h40, 32'h0, 2'b11, "R11"); rd(32'h40, "R11");
    wr(32'h41, 32'h0, "R11"); rd(32'h40, "R11");

    // software reset: plain config write, then reset write
    wr(32'h10, 32'hFFFF_FFFD, "R3"); rd(32'h10, "R3"); rd(32'h44, "R3");
    wr(32'h10, 32'hFFFF_FFFF, "R3");
    read_all("R3");
    wr(32'h44, 32'h0000_1200, "R3"); rd(32'h44, "R3");

    // pseudo-random sweep over every stored address
    for (int i = 0; i < 60; i++) begin
      logic [31:0] v;
      v = (32'h9E37_79B9 * (i + 1)) ^ (32'h7F4A_7C15 >> (i % 7));
      foreach (wlist[j]) begin
        wr(wlist[j], v ^ (j * 32'h0101_0101), "R6");
        rd(wlist[j], "R6");
      end
    end
    read_all("R12");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule